// File: doc/BRIEF.md
# Page Access Permission Evaluator

This block decides whether a single memory access may go ahead once the page table entry for the page has been found. It takes the second word of that entry, the key bits of the matching segment, the privilege state of the core and two authority mask words. From these it works out the read, write and execute rights for the page and compares them with the kind of access requested: a load, a store or an instruction fetch. If the access is refused, it raises a fault and sets cause bits. The cause bits are encoded one way for fetches and another way for data accesses. If the access is granted, it reports whether the entry's referenced bit and changed bit have to be written back.

Rights come from a 3-bit protection code that is decoded through one of two tables, picked by a key bit. The result is then narrowed by the page's no-execute and guarded bits and by a per-class 2-bit field of each mask word. A fetch to a segment marked no-execute is refused before any page-level decision is made. Each request is presented for one cycle with `req_valid`. The verdict appears one clock later, qualified by `resp_valid`.

Top module: `pae_access_eval`

## Requirements
- R1: `resp_valid` is high in exactly the cycle after each cycle with `req_valid` high. The verdict outputs update only in that cycle and hold their value otherwise. A synchronous reset clears every output to 0.
- R2: The key bit is `seg_key_user` when `user_mode` is 1 and `seg_key_super` when `user_mode` is 0.
- R3: The protection code is {`pte_word[63]`, `pte_word[1:0]`}. `rights` is {read, write, execute} (bit 2 = read). With key 0, codes 0, 1 and 2 give read/write/execute, codes 3 and 6 give read/execute, and codes 4, 5 and 7 give nothing.
- R4: With key 1, codes 2 gives read/write/execute, codes 1 and 3 give read/execute, and codes 0, 4, 5, 6 and 7 give nothing.
- R5: If the no-execute bit `pte_word[2]` or the guarded bit `pte_word[3]` is 1, execute is removed. Read and write are left as they were.
- R6: The class key is `pte_word[13:9]`. When `mask_check_en` is 1, the field `amr_word[2*(31-key)+1 : 2*(31-key)]` applies: its upper bit removes write and its lower bit removes read. When `mask_check_en` is 0, the field has no effect.
- R7: When `mask_check_en` is 1, bit `iamr_word[2*(31-key)]` removes execute.
- R8: The cause bits are {store, mask, protection, no-exec/guard} (bit 0 = no-exec/guard). On a refused fetch, bit 0 is set if R5 removed execute. Otherwise bit 1 is set if the code table withheld execute. Bit 2 is set if R7 removed execute. Bit 3 stays 0.
- R9: On a refused load or store, bit 1 is set if the code table withheld the needed right. Bit 2 is set if R6 withheld it. Bit 3 is set for a store. Bit 0 stays 0.
- R10: A fetch with `seg_noexec` = 1 is refused with cause 4'b0001, `rights` = 0 and no update flags, whatever the page word holds.
- R11: On a granted access, `set_ref` equals the inverse of the referenced bit `pte_word[8]`. On a refused access, `set_ref` and `set_chg` are 0.
- R12: On a granted store, `set_chg` equals the inverse of the changed bit `pte_word[7]`. On a granted load or fetch, `set_chg` is 0. On a granted load or fetch with the changed bit clear, write is removed from `rights`.
- R13: `req_kind` encodes 0 = load, 1 = store and 2 = fetch. Code 3 is treated as a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | Access kind (R13) |
| user_mode | input | 1 | Core is in user state |
| seg_key_user | input | 1 | Segment key used in user state |
| seg_key_super | input | 1 | Segment key used in supervisor state |
| seg_noexec | input | 1 | Segment forbids instruction fetch |
| pte_word | input | 64 | Second word of the page table entry |
| amr_word | input | 64 | Data authority mask, 2 bits per class key |
| iamr_word | input | 64 | Instruction authority mask, 2 bits per class key |
| mask_check_en | input | 1 | Enables the mask-word restrictions |
| resp_valid | output | 1 | Verdict present this cycle |
| rights | output | 3 | Granted rights {read, write, execute} |
| fault | output | 1 | Access refused |
| cause | output | 4 | Fault causes {store, mask, protection, no-exec/guard} |
| set_ref | output | 1 | Referenced bit must be set |
| set_chg | output | 1 | Changed bit must be set |

## Verification
On every cycle the assertions check the following:
- the one-cycle valid timing;
- that a segment-level fetch refusal always yields cause 0001 with no rights;
- that fetch causes never carry the store bit or both the guard and protection bits together;
- that the changed-bit update never follows a non-store;
- that write is never granted on a load or fetch while the changed bit is clear.

The mapping of protection codes to rights under each key can only be shown by the bench's scenarios, and likewise:
- which mask field a class key addresses, including keys 0 and 31;
- the effect of turning the mask check off;
- how each cause bit combines on a refusal.

// File: rtl/pae_pkg.sv
package pae_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_SPARE = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } rights_t;

    typedef struct packed {
        logic store;
        logic mask;
        logic prot;
        logic ng;
    } cause_t;

    localparam rights_t RIGHTS_NONE = 3'b000;
    localparam rights_t RIGHTS_RX   = 3'b101;
    localparam rights_t RIGHTS_RWX  = 3'b111;

    // Field positions inside the page word (the code's high bit is the word's MSB)
    localparam int PTE_PP_LSB  = 0;
    localparam int PTE_NX_BIT  = 2;
    localparam int PTE_GD_BIT  = 3;
    localparam int PTE_CHG_BIT = 7;
    localparam int PTE_REF_BIT = 8;
    localparam int PTE_KEY_LSB = 9;

    // Decode of the 3-bit protection code under the selected key bit
    function automatic rights_t code_rights(input logic key, input logic [2:0] code);
        rights_t r;
        r = RIGHTS_NONE;
        if (!key) begin
            case (code)
                3'd0, 3'd1, 3'd2: r = RIGHTS_RWX;
                3'd3, 3'd6:       r = RIGHTS_RX;
                default:          r = RIGHTS_NONE;
            endcase
        end else begin
            case (code)
                3'd2:       r = RIGHTS_RWX;
                3'd1, 3'd3: r = RIGHTS_RX;
                default:    r = RIGHTS_NONE;
            endcase
        end
        return r;
    endfunction

    // Right that an access of the given kind needs
    function automatic rights_t needed_right(input acc_kind_e kind);
        rights_t r;
        case (kind)
            ACC_STORE: r = 3'b010;
            ACC_FETCH: r = 3'b001;
            default:   r = 3'b100;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pae_code_table.sv
module pae_code_table
    import pae_pkg::*;
(
    input  logic       user_mode,
    input  logic       seg_key_user,
    input  logic       seg_key_super,
    input  logic [2:0] prot_code,
    input  logic       page_noexec,
    input  logic       page_guard,
    output rights_t    table_rights,
    output rights_t    ng_rights
);

    logic key_sel;

    always_comb begin
        key_sel      = user_mode ? seg_key_user : seg_key_super;
        table_rights = code_rights(key_sel, prot_code);
        ng_rights    = RIGHTS_RWX;
        ng_rights.ex = !(page_noexec || page_guard);
    end

endmodule

// File: rtl/pae_mask_filter.sv
module pae_mask_filter
    import pae_pkg::*;
#(
    parameter int KEY_W        = 5,
    parameter bit IAMR_PRESENT = 1'b1,
    localparam int NKEYS       = 1 << KEY_W,
    localparam int MASK_W      = 2 * NKEYS,
    localparam int IDX_W       = KEY_W + 1
) (
    input  logic [KEY_W-1:0]  class_key,
    input  logic [MASK_W-1:0] amr_word,
    input  logic [MASK_W-1:0] iamr_word,
    input  logic              enable,
    output rights_t           mask_rights
);

    // Key k owns the 2-bit field starting at 2*(NKEYS-1-k), i.e. {~k, 0}
    logic [IDX_W-1:0] field_base;
    logic [1:0]       data_field;

    assign field_base = {~class_key, 1'b0};
    assign data_field = amr_word[field_base +: 2];

    assign mask_rights.wr = !(enable && data_field[1]);
    assign mask_rights.rd = !(enable && data_field[0]);

    generate
        if (IAMR_PRESENT) begin : g_iamr
            assign mask_rights.ex = !(enable && iamr_word[field_base]);
        end else begin : g_no_iamr
            logic unused_iamr;
            assign unused_iamr    = ^iamr_word;
            assign mask_rights.ex = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/pae_fault_judge.sv
module pae_fault_judge
    import pae_pkg::*;
(
    input  acc_kind_e kind,
    input  logic      seg_noexec,
    input  rights_t   table_rights,
    input  rights_t   ng_rights,
    input  rights_t   mask_rights,
    input  logic      pte_ref,
    input  logic      pte_chg,
    output logic      fault,
    output cause_t    cause,
    output rights_t   rights,
    output logic      set_ref,
    output logic      set_chg
);

    rights_t need;
    rights_t combined;
    logic    is_store;
    logic    is_fetch;
    logic    denied;

    always_comb begin
        need     = needed_right(kind);
        combined = rights_t'(table_rights & ng_rights & mask_rights);
        is_store = (kind == ACC_STORE);
        is_fetch = (kind == ACC_FETCH);
        denied   = |(need & ~combined);

        fault   = 1'b0;
        cause   = '0;
        rights  = combined;
        set_ref = 1'b0;
        set_chg = 1'b0;

        if (is_fetch && seg_noexec) begin
            fault    = 1'b1;
            cause.ng = 1'b1;
            rights   = RIGHTS_NONE;
        end else if (denied) begin
            fault = 1'b1;
            if (is_fetch) begin
                cause.ng   = !ng_rights.ex;
                cause.prot = ng_rights.ex && !table_rights.ex;
                cause.mask = !mask_rights.ex;
            end else begin
                cause.prot  = |(need & ~table_rights);
                cause.mask  = |(need & ~mask_rights);
                cause.store = is_store;
            end
        end else begin
            set_ref = !pte_ref;
            set_chg = is_store && !pte_chg;
            if (!is_store && !pte_chg) begin
                rights.wr = 1'b0;
            end
        end
    end

endmodule

// File: rtl/pae_access_eval.sv
module pae_access_eval
    import pae_pkg::*;
#(
    parameter int PTE_W        = 64,
    parameter int KEY_W        = 5,
    parameter bit IAMR_PRESENT = 1'b1,
    localparam int MASK_W      = 2 * (1 << KEY_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic              user_mode,
    input  logic              seg_key_user,
    input  logic              seg_key_super,
    input  logic              seg_noexec,
    input  logic [PTE_W-1:0]  pte_word,
    input  logic [MASK_W-1:0] amr_word,
    input  logic [MASK_W-1:0] iamr_word,
    input  logic              mask_check_en,
    output logic              resp_valid,
    output logic [2:0]        rights,
    output logic              fault,
    output logic [3:0]        cause,
    output logic              set_ref,
    output logic              set_chg
);

    localparam int KEY_MSB = PTE_KEY_LSB + KEY_W - 1;

    // Page word fields
    logic [2:0]       prot_code;
    logic [KEY_W-1:0] class_key;
    logic             unused_pte_bits;

    assign prot_code       = {pte_word[PTE_W-1], pte_word[PTE_PP_LSB +: 2]};
    assign class_key       = pte_word[PTE_KEY_LSB +: KEY_W];
    assign unused_pte_bits = ^{pte_word[PTE_CHG_BIT-1:PTE_GD_BIT+1],
                               pte_word[PTE_W-2:KEY_MSB+1]};

    rights_t   table_rights;
    rights_t   ng_rights;
    rights_t   mask_rights;
    rights_t   rights_d;
    cause_t    cause_d;
    logic      fault_d;
    logic      set_ref_d;
    logic      set_chg_d;

    pae_code_table u_code_table (
        .user_mode     (user_mode),
        .seg_key_user  (seg_key_user),
        .seg_key_super (seg_key_super),
        .prot_code     (prot_code),
        .page_noexec   (pte_word[PTE_NX_BIT]),
        .page_guard    (pte_word[PTE_GD_BIT]),
        .table_rights  (table_rights),
        .ng_rights     (ng_rights)
    );

    pae_mask_filter #(
        .KEY_W        (KEY_W),
        .IAMR_PRESENT (IAMR_PRESENT)
    ) u_mask_filter (
        .class_key   (class_key),
        .amr_word    (amr_word),
        .iamr_word   (iamr_word),
        .enable      (mask_check_en),
        .mask_rights (mask_rights)
    );

    pae_fault_judge u_fault_judge (
        .kind         (acc_kind_e'(req_kind)),
        .seg_noexec   (seg_noexec),
        .table_rights (table_rights),
        .ng_rights    (ng_rights),
        .mask_rights  (mask_rights),
        .pte_ref      (pte_word[PTE_REF_BIT]),
        .pte_chg      (pte_word[PTE_CHG_BIT]),
        .fault        (fault_d),
        .cause        (cause_d),
        .rights       (rights_d),
        .set_ref      (set_ref_d),
        .set_chg      (set_chg_d)
    );

    // Output register stage
    logic    resp_valid_q;
    rights_t rights_q;
    cause_t  cause_q;
    logic    fault_q;
    logic    set_ref_q;
    logic    set_chg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid_q <= 1'b0;
            rights_q     <= RIGHTS_NONE;
            cause_q      <= '0;
            fault_q      <= 1'b0;
            set_ref_q    <= 1'b0;
            set_chg_q    <= 1'b0;
        end else begin
            resp_valid_q <= req_valid;
            if (req_valid) begin
                rights_q  <= rights_d;
                cause_q   <= cause_d;
                fault_q   <= fault_d;
                set_ref_q <= set_ref_d;
                set_chg_q <= set_chg_d;
            end
        end
    end

    assign resp_valid = resp_valid_q;
    assign rights     = rights_q;
    assign cause      = cause_q;
    assign fault      = fault_q;
    assign set_ref    = set_ref_q;
    assign set_chg    = set_chg_q;

    // R1: verdict appears one cycle after each request and only then
    a_r1_resp_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> resp_valid);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !resp_valid);

    // R10: segment-level fetch refusal
    a_r10_seg_refuse: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 2'd2 && seg_noexec)
        |=> (fault && cause == 4'b0001 && rights == 3'b000 && !set_ref && !set_chg));

    // R8: fetch causes never carry store, and guard/protection are exclusive
    a_r8_fetch_cause: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 2'd2) |=> (!cause[3] && $onehot0(cause[1:0])));

    // R11: no entry update on a refused access
    a_r11_no_update_on_fault: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && fault) |-> (!set_ref && !set_chg));

    // R12: changed bit only for stores, and write withheld otherwise
    a_r12_chg_store_only: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind != 2'd1) |=> !set_chg);
    a_r12_write_withheld: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind != 2'd1 && !pte_word[PTE_CHG_BIT]) |=> (fault || !rights[1]));

endmodule

// File: tb/pae_access_eval_tb_top.sv
module pae_access_eval_tb_top;

    typedef struct packed {
        logic [1:0] kind;
        logic       user;
        logic       ksu;
        logic       kss;
        logic       segnx;
        logic [2:0] pp;
        logic       nx;
        logic       gd;
        logic       rf;
        logic       ch;
        logic [4:0] key;
        logic [1:0] afld;
        logic       ifld;
        logic       en;
    } vec_t;

    localparam int NV = 19;

    // kind user ksu kss segnx pp nx gd rf ch key afld ifld en
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd3,  2'b00, 1'b0, 1'b1},
        '{2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 3'd2, 1'b0, 1'b0, 1'b1, 1'b0, 5'd4,  2'b00, 1'b0, 1'b1},
        '{2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd3, 1'b0, 1'b0, 1'b1, 1'b1, 5'd4,  2'b00, 1'b0, 1'b1},
        '{2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd9,  2'b00, 1'b0, 1'b1},
        '{2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd9,  2'b00, 1'b0, 1'b1},
        '{2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 3'd2, 1'b0, 1'b0, 1'b0, 1'b1, 5'd12, 2'b00, 1'b0, 1'b1},
        '{2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 3'd1, 1'b0, 1'b0, 1'b0, 1'b1, 5'd12, 2'b00, 1'b0, 1'b1},
        '{2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 3'd2, 1'b1, 1'b0, 1'b0, 1'b1, 5'd1,  2'b00, 1'b0, 1'b1},
        '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd2, 1'b0, 1'b1, 1'b1, 1'b1, 5'd1,  2'b00, 1'b0, 1'b1},
        '{2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 3'd4, 1'b0, 1'b0, 1'b0, 1'b1, 5'd2,  2'b00, 1'b0, 1'b1},
        '{2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 1'b0, 1'b0, 1'b0, 1'b1, 5'd0,  2'b10, 1'b0, 1'b1},
        '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 1'b0, 1'b0, 1'b0, 1'b1, 5'd31, 2'b01, 1'b0, 1'b1},
        '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 1'b0, 1'b0, 1'b0, 1'b1, 5'd5,  2'b11, 1'b1, 1'b0},
        '{2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 5'd7,  2'b00, 1'b1, 1'b1},
        '{2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd6,  2'b00, 1'b0, 1'b1},
        '{2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 3'd6, 1'b0, 1'b1, 1'b0, 1'b1, 5'd8,  2'b00, 1'b1, 1'b1},
        '{2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 3'd3, 1'b0, 1'b0, 1'b1, 1'b1, 5'd8,  2'b00, 1'b0, 1'b1},
        '{2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd7, 1'b0, 1'b0, 1'b0, 1'b1, 5'd10, 2'b00, 1'b0, 1'b1},
        '{2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd6, 1'b0, 1'b0, 1'b0, 1'b1, 5'd11, 2'b00, 1'b0, 1'b1}
    };

    localparam string TAGS [NV] = '{
        "R3 R11 R12 load key0 code0",
        "R12 R11 store sets changed",
        "R9 R3 store to code3",
        "R2 R4 user key1 code0",
        "R2 supervisor key0 code0",
        "R4 store key1 code2",
        "R4 R12 fetch key1 code1",
        "R5 R8 fetch no-exec page",
        "R5 load guarded page",
        "R8 R3 fetch code4",
        "R6 R9 store key0 mask",
        "R6 load key31 mask",
        "R6 mask check disabled",
        "R7 R8 fetch instruction mask",
        "R10 segment no-exec fetch",
        "R8 R5 R7 guard plus mask",
        "R13 spare kind as load",
        "R4 key1 code7",
        "R3 R9 store key0 code6"
    };

    logic        clk;
    logic        rst;
    logic        req_valid;
    logic [1:0]  req_kind;
    logic        user_mode;
    logic        seg_key_user;
    logic        seg_key_super;
    logic        seg_noexec;
    logic [63:0] pte_word;
    logic [63:0] amr_word;
    logic [63:0] iamr_word;
    logic        mask_check_en;
    logic        resp_valid;
    logic [2:0]  rights;
    logic        fault;
    logic [3:0]  cause;
    logic        set_ref;
    logic        set_chg;

    int n_checks = 0;
    int n_fails  = 0;

    pae_access_eval dut_i (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_kind      (req_kind),
        .user_mode     (user_mode),
        .seg_key_user  (seg_key_user),
        .seg_key_super (seg_key_super),
        .seg_noexec    (seg_noexec),
        .pte_word      (pte_word),
        .amr_word      (amr_word),
        .iamr_word     (iamr_word),
        .mask_check_en (mask_check_en),
        .resp_valid    (resp_valid),
        .rights        (rights),
        .fault         (fault),
        .cause         (cause),
        .set_ref       (set_ref),
        .set_chg       (set_chg)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    // Expected {resp_valid, rights[2:0], fault, cause[3:0], set_ref, set_chg}
    function automatic logic [10:0] model(input vec_t v);
        logic       key;
        logic [2:0] tbl, ngm, msk, comb, need;
        logic       st, fe, flt, sref, schg;
        logic [3:0] cs;
        logic [2:0] rt;
        key = v.user ? v.ksu : v.kss;
        if (!key) begin
            if (v.pp <= 3'd2)                   tbl = 3'b111;
            else if (v.pp == 3'd3 || v.pp == 3'd6) tbl = 3'b101;
            else                                tbl = 3'b000;
        end else begin
            if (v.pp == 3'd2)                    tbl = 3'b111;
            else if (v.pp == 3'd1 || v.pp == 3'd3) tbl = 3'b101;
            else                                 tbl = 3'b000;
        end
        ngm  = {2'b11, !(v.nx || v.gd)};
        msk  = {!(v.en && v.afld[0]), !(v.en && v.afld[1]), !(v.en && v.ifld)};
        comb = tbl & ngm & msk;
        st   = (v.kind == 2'd1);
        fe   = (v.kind == 2'd2);
        need = st ? 3'b010 : (fe ? 3'b001 : 3'b100);
        flt = 1'b0; cs = 4'b0; sref = 1'b0; schg = 1'b0; rt = comb;
        if (fe && v.segnx) begin
            flt = 1'b1; cs = 4'b0001; rt = 3'b000;
        end else if ((need & comb) == 3'b000) begin
            flt = 1'b1;
            if (fe) begin
                cs[0] = !ngm[0];
                cs[1] = ngm[0] && !tbl[0];
                cs[2] = !msk[0];
            end else begin
                cs[1] = (need & tbl) == 3'b000;
                cs[2] = (need & msk) == 3'b000;
                cs[3] = st;
            end
        end else begin
            sref = !v.rf;
            schg = st && !v.ch;
            if (!st && !v.ch) rt[1] = 1'b0;
        end
        return {1'b1, rt, flt, cs, sref, schg};
    endfunction

    function automatic logic [10:0] observed();
        return {resp_valid, rights, fault, cause, set_ref, set_chg};
    endfunction

    task automatic check(input string tag, input logic [10:0] act, input logic [10:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        int base;
        base = 2 * (31 - int'(v.key));
        req_valid     = 1'b1;
        req_kind      = v.kind;
        user_mode     = v.user;
        seg_key_user  = v.ksu;
        seg_key_super = v.kss;
        seg_noexec    = v.segnx;
        pte_word      = '1;
        pte_word[1:0] = v.pp[1:0];
        pte_word[63]  = v.pp[2];
        pte_word[2]   = v.nx;
        pte_word[3]   = v.gd;
        pte_word[7]   = v.ch;
        pte_word[8]   = v.rf;
        pte_word[13:9] = v.key;
        amr_word      = '1;
        amr_word[base +: 2] = v.afld;
        iamr_word     = '1;
        iamr_word[base] = v.ifld;
        mask_check_en = v.en;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [10:0] held;
        rst = 1'b1; req_valid = 1'b0; req_kind = 2'd0; user_mode = 1'b0;
        seg_key_user = 1'b0; seg_key_super = 1'b0; seg_noexec = 1'b0;
        pte_word = '0; amr_word = '0; iamr_word = '0; mask_check_en = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset state", observed(), 11'b0);
        rst = 1'b0;

        // Vector table, one request per cycle, back to back
        @(negedge clk);
        drive(VECS[0]);
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            check(TAGS[i], observed(), model(VECS[i]));
            if (i + 1 < NV) drive(VECS[i + 1]);
        end

        // R1: no request -> valid drops and verdict holds
        held = observed();
        req_valid = 1'b0;
        drive(VECS[3]);
        req_valid = 1'b0;
        @(negedge clk);
        check("R1 hold without request", observed(), {1'b0, held[9:0]});

        // R6: neighbouring key fields must not leak into key 0
        drive(VECS[10]);
        amr_word[61:60] = 2'b00;
        amr_word[63:62] = 2'b00;
        @(negedge clk);
        check("R6 key0 field cleared grants store", observed(),
              {1'b1, 3'b111, 1'b0, 4'b0000, 1'b1, 1'b0});

        // R10: segment refusal regardless of a fully permissive page
        drive(VECS[14]);
        pte_word[8] = 1'b1;
        @(negedge clk);
        check("R10 refusal on permissive page", observed(),
              {1'b1, 3'b000, 1'b1, 4'b0001, 1'b0, 1'b0});

        // R1: reset in the middle clears outputs
        req_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset clears verdict", observed(), 11'b0);
        rst = 1'b0;
        @(negedge clk);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule